// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a single-data-rate SDRAM interface with four banks, a 12-bit address and a 32-bit data bus split into four bytes. On every rising clock edge it samples the clock enable, the active-low chip select and RAS/CAS/WE strobes, the bank address, the address and the byte masks. From them it decodes the command and keeps a small state machine per bank (idle or active, with the open row). It also runs a burst state machine and a power-mode state machine.

For each accepted read or write it reports the target bank, the column and the auto-precharge request. The burst machine times the access, applies auto-precharge when the access ends and drives per-byte write enables. The dqm stage makes a registered read output-enable that follows the byte masks two clocks late. The power machine classifies what a low clock enable means, depending on whether banks are open or a burst is running. The last mode-register op-code is kept for the rest of the device.

States and transitions. Bank machine: `BK_IDLE` goes to `BK_ACTIVE` on ACTIVE. `BK_ACTIVE` returns to `BK_IDLE` on a precharge or on the close raised by an auto-precharged access. Burst machine: `BU_IDLE` goes to `BU_READ` or `BU_WRITE` on an accepted access. It returns to `BU_IDLE` when its beat count runs out or on BURST TERMINATE. A new access restarts it. Power machine: `PM_RUN` goes to `PM_SUSPEND`, `PM_ACT_PD`, `PM_SELF_REF` or `PM_PRE_PD` on an edge with the clock enable low. Every low-power state returns to `PM_RUN` on the first edge with the clock enable high.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After each edge `cmd_o` holds the command decoded at that edge, taken from {ras_n, cas_n, we_n}. The codes are NOP=0 (111), ACTIVE=1 (011), READ=2 (101), WRITE=3 (100), PRECHARGE=4 (010), REFRESH=5 (001), LOAD MODE=6 (000) and BURST TERMINATE=7 (110). It holds NOP=0 after any edge with `cke_i` low. Reset clears every output to zero.
- R2: An edge with `cs_n_i` high is a NOP whatever the strobes say: `cmd_o` is 0 and no bank changes state.
- R3: ACTIVE to an idle bank sets `bank_active_o[ba]` and stores all 12 address bits in `open_rows_o[ba*12 +: 12]`.
- R4: READ or WRITE to an active bank sets `acc_bank_o`=ba, `col_o`=addr[8:0] and `auto_pre_o`=addr[10]. `burst_active_o` is then high for BURST_LEN-1 edges.
- R5: PRECHARGE with addr[10] high closes every bank. With addr[10] low it closes only bank ba.
- R6: An access with auto-precharge closes its bank at the edge where its burst ends. With BURST_LEN=4 that is the third edge after the command.
- R7: READ or WRITE to an idle bank pulses `acc_err_o` for one cycle and is otherwise ignored: no burst starts and `col_o` keeps its old value.
- R8: BURST TERMINATE ends a running burst at its edge.
- R9: An edge with `cke_i` low in `PM_RUN` sets `pwr_mode_o` as follows, checked in this order: 4 (clock suspend) if a burst is running; 3 (active power-down) if any bank is active; 2 (self refresh) if the command is REFRESH; otherwise 1 (precharge power-down).
- R10: While `cke_i` stays low the power mode, the bank states and the burst count hold. The first edge with `cke_i` high returns `pwr_mode_o` to 0 and the burst resumes counting.
- R11: During a write beat (the WRITE cycle itself and the burst cycles after it, with `cke_i` high), `wr_be_o[n]` is the inverse of `dqm_i[n]` in the same cycle. Byte n is data bits 8n..8n+7. Outside write beats `wr_be_o` is 0.
- R12: A read beat sampled at edge k sets `rd_oe_o` to the inverse of the `dqm_i` sampled at edge k, visible after edge k+2. Cycles without a read beat give 0.
- R13: LOAD MODE stores {ba, addr} in `mode_op_o` (ba in bits 13:12).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| ba_i | input | 2 | Bank address |
| addr_i | input | 12 | Row, column or op-code address |
| dqm_i | input | 4 | Per-byte data masks |
| cmd_o | output | 3 | Last decoded command |
| bank_active_o | output | 4 | One bit per bank, high while a row is open |
| open_rows_o | output | 48 | Open row of each bank, 12 bits per bank |
| acc_bank_o | output | 2 | Bank of the last accepted access |
| col_o | output | 9 | Column of the last accepted access |
| auto_pre_o | output | 1 | Auto-precharge flag of the last accepted access |
| acc_err_o | output | 1 | One-cycle pulse for an access to an idle bank |
| burst_active_o | output | 1 | Burst beats remain |
| pwr_mode_o | output | 3 | Power mode code |
| mode_op_o | output | 14 | Last mode op-code |
| wr_be_o | output | 4 | Per-byte write enables, same cycle |
| rd_oe_o | output | 4 | Per-byte read output enables, two-clock mask latency |

## Verification
The bench builds the block with its default parameters: four banks, 12-bit rows, 9-bit columns, a burst of four and a read-mask latency of two. A four-beat burst leaves several cycles in which to change the masks between beats, stop the burst early, or drop the clock enable partway through. That makes clock suspend, a frozen beat count and the delayed auto-precharge close all reachable. The two-clock mask latency is short enough that one read shows both a masked byte and the unmasked beats around it.

// File: rtl/sdtrk_pkg.sv
package sdtrk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_LMR = 3'd6,
        CMD_BST = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        PM_RUN      = 3'd0,
        PM_PRE_PD   = 3'd1,
        PM_SELF_REF = 3'd2,
        PM_ACT_PD   = 3'd3,
        PM_SUSPEND  = 3'd4
    } pm_e;

    typedef enum logic {
        BK_IDLE   = 1'b0,
        BK_ACTIVE = 1'b1
    } bank_e;

    typedef enum logic [1:0] {
        BU_IDLE  = 2'd0,
        BU_READ  = 2'd1,
        BU_WRITE = 2'd2
    } burst_e;

endpackage

// File: rtl/sdtrk_decode.sv
module sdtrk_decode
    import sdtrk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_LMR;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdtrk_bank.sv
module sdtrk_bank
    import sdtrk_pkg::*;
#(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_req,
    input  logic             close_req,
    input  logic [ROW_W-1:0] row_i,
    output logic             active_o,
    output logic [ROW_W-1:0] row_o
);

    bank_e             state_q, state_d;
    logic [ROW_W-1:0]  row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == BK_IDLE && open_req) begin
                row_q <= row_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_IDLE:   if (open_req)  state_d = BK_ACTIVE;
            BK_ACTIVE: if (close_req) state_d = BK_IDLE;
            default:   state_d = BK_IDLE;
        endcase
    end

    always_comb begin
        active_o = (state_q == BK_ACTIVE);
        row_o    = row_q;
    end

endmodule

// File: rtl/sdtrk_burst.sv
module sdtrk_burst
    import sdtrk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BURST_LEN = 4,
    localparam int BA_W     = $clog2(NUM_BANKS),
    localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            start,
    input  logic            start_wr,
    input  logic            start_ap,
    input  logic [BA_W-1:0] start_bank,
    input  logic            stop,
    output logic            active_o,
    output logic            is_rd_o,
    output logic            is_wr_o,
    output logic            close_o,
    output logic [BA_W-1:0] close_bank_o
);

    localparam logic [CNT_W-1:0] FIRST_CNT = CNT_W'(BURST_LEN - 1);
    localparam logic [CNT_W-1:0] ONE_CNT   = CNT_W'(1);
    localparam bit               SINGLE    = (BURST_LEN == 1);

    burst_e            state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              ap_q;
    logic [BA_W-1:0]   bank_q;
    logic              prev_ends;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BU_IDLE;
            cnt_q   <= '0;
            ap_q    <= 1'b0;
            bank_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (adv && start) begin
                ap_q   <= start_ap;
                bank_q <= start_bank;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (adv) begin
            if (start) begin
                state_d = SINGLE ? BU_IDLE : (start_wr ? BU_WRITE : BU_READ);
                cnt_d   = FIRST_CNT;
            end else begin
                unique case (state_q)
                    BU_IDLE: begin
                        cnt_d = '0;
                    end
                    BU_READ, BU_WRITE: begin
                        if (stop || cnt_q == ONE_CNT) begin
                            state_d = BU_IDLE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q - ONE_CNT;
                        end
                    end
                    default: begin
                        state_d = BU_IDLE;
                        cnt_d   = '0;
                    end
                endcase
            end
        end
    end

    always_comb begin
        prev_ends    = adv && (state_q != BU_IDLE) && (start || stop || cnt_q == ONE_CNT);
        active_o     = (state_q != BU_IDLE);
        is_rd_o      = (state_q == BU_READ);
        is_wr_o      = (state_q == BU_WRITE);
        close_o      = (prev_ends && ap_q) || (SINGLE && adv && start && start_ap);
        close_bank_o = (prev_ends && ap_q) ? bank_q : start_bank;
    end

endmodule

// File: rtl/sdtrk_dqm.sv
module sdtrk_dqm #(
    parameter int BYTES = 4,
    parameter int LAT   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             wr_win,
    input  logic             rd_win,
    input  logic [BYTES-1:0] dqm,
    output logic [BYTES-1:0] wr_be,
    output logic [BYTES-1:0] rd_oe
);

    localparam int STAGES = LAT + 1;

    logic [STAGES-1:0] win_q;
    logic [BYTES-1:0]  en_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q[0] <= 1'b0;
            en_q[0]  <= '0;
        end else if (adv) begin
            win_q[0] <= rd_win;
            en_q[0]  <= ~dqm;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                win_q[s] <= 1'b0;
                en_q[s]  <= '0;
            end else if (adv) begin
                win_q[s] <= win_q[s-1];
                en_q[s]  <= en_q[s-1];
            end
        end
    end

    always_comb begin
        wr_be = wr_win ? ~dqm : '0;
        rd_oe = win_q[STAGES-1] ? en_q[STAGES-1] : '0;
    end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdtrk_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int ROW_W       = 12,
    parameter int COL_W       = 9,
    parameter int AP_BIT      = 10,
    parameter int BYTES       = 4,
    parameter int BURST_LEN   = 4,
    parameter int RD_MASK_LAT = 2,
    localparam int BA_W       = $clog2(NUM_BANKS),
    localparam int OP_W       = BA_W + ROW_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cke_i,
    input  logic                       cs_n_i,
    input  logic                       ras_n_i,
    input  logic                       cas_n_i,
    input  logic                       we_n_i,
    input  logic [BA_W-1:0]            ba_i,
    input  logic [ROW_W-1:0]           addr_i,
    input  logic [BYTES-1:0]           dqm_i,
    output logic [2:0]                 cmd_o,
    output logic [NUM_BANKS-1:0]       bank_active_o,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows_o,
    output logic [BA_W-1:0]            acc_bank_o,
    output logic [COL_W-1:0]           col_o,
    output logic                       auto_pre_o,
    output logic                       acc_err_o,
    output logic                       burst_active_o,
    output logic [2:0]                 pwr_mode_o,
    output logic [OP_W-1:0]            mode_op_o,
    output logic [BYTES-1:0]           wr_be_o,
    output logic [BYTES-1:0]           rd_oe_o
);

    cmd_e                  cmd_now;
    logic                  is_access;
    logic                  acc_hit, acc_miss;
    logic                  rd_now, wr_now, bst_now;
    logic                  bu_active, bu_rd, bu_wr;
    logic                  bu_close;
    logic [BA_W-1:0]       bu_close_bank;
    logic                  wr_win, rd_win;
    logic [NUM_BANKS-1:0]  open_req, close_req;
    pm_e                   pm_q, pm_d;

    sdtrk_decode u_decode (
        .cs_n  (cs_n_i),
        .ras_n (ras_n_i),
        .cas_n (cas_n_i),
        .we_n  (we_n_i),
        .cmd   (cmd_now)
    );

    always_comb begin
        is_access = cke_i && (cmd_now == CMD_RD || cmd_now == CMD_WR);
        acc_hit   = is_access && bank_active_o[ba_i];
        acc_miss  = is_access && !bank_active_o[ba_i];
        rd_now    = acc_hit && (cmd_now == CMD_RD);
        wr_now    = acc_hit && (cmd_now == CMD_WR);
        bst_now   = cke_i && (cmd_now == CMD_BST);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_comb begin
            open_req[b]  = cke_i && (cmd_now == CMD_ACT) && (ba_i == BA_W'(b));
            close_req[b] = (cke_i && (cmd_now == CMD_PRE)
                            && (addr_i[AP_BIT] || ba_i == BA_W'(b)))
                        || (bu_close && bu_close_bank == BA_W'(b));
        end

        sdtrk_bank #(.ROW_W(ROW_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .open_req  (open_req[b]),
            .close_req (close_req[b]),
            .row_i     (addr_i),
            .active_o  (bank_active_o[b]),
            .row_o     (open_rows_o[b*ROW_W +: ROW_W])
        );
    end

    sdtrk_burst #(
        .NUM_BANKS (NUM_BANKS),
        .BURST_LEN (BURST_LEN)
    ) u_burst (
        .clk          (clk),
        .rst_n        (rst_n),
        .adv          (cke_i),
        .start        (acc_hit),
        .start_wr     (cmd_now == CMD_WR),
        .start_ap     (addr_i[AP_BIT]),
        .start_bank   (ba_i),
        .stop         (bst_now),
        .active_o     (bu_active),
        .is_rd_o      (bu_rd),
        .is_wr_o      (bu_wr),
        .close_o      (bu_close),
        .close_bank_o (bu_close_bank)
    );

    always_comb begin
        wr_win = wr_now || (cke_i && bu_wr && !acc_hit && !bst_now);
        rd_win = rd_now || (cke_i && bu_rd && !acc_hit && !bst_now);
    end

    sdtrk_dqm #(
        .BYTES (BYTES),
        .LAT   (RD_MASK_LAT)
    ) u_dqm (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (cke_i),
        .wr_win (wr_win),
        .rd_win (rd_win),
        .dqm    (dqm_i),
        .wr_be  (wr_be_o),
        .rd_oe  (rd_oe_o)
    );

    // Power-mode state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pm_q <= PM_RUN;
        end else begin
            pm_q <= pm_d;
        end
    end

    always_comb begin
        pm_d = pm_q;
        unique case (pm_q)
            PM_RUN: begin
                if (!cke_i) begin
                    if (bu_active)                pm_d = PM_SUSPEND;
                    else if (|bank_active_o)      pm_d = PM_ACT_PD;
                    else if (cmd_now == CMD_REF)  pm_d = PM_SELF_REF;
                    else                          pm_d = PM_PRE_PD;
                end
            end
            PM_PRE_PD, PM_SELF_REF, PM_ACT_PD, PM_SUSPEND: begin
                if (cke_i) pm_d = PM_RUN;
            end
            default: pm_d = PM_RUN;
        endcase
    end

    // Registered command, access and op-code outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_o      <= 3'(CMD_NOP);
            acc_bank_o <= '0;
            col_o      <= '0;
            auto_pre_o <= 1'b0;
            acc_err_o  <= 1'b0;
            mode_op_o  <= '0;
        end else begin
            cmd_o     <= cke_i ? 3'(cmd_now) : 3'(CMD_NOP);
            acc_err_o <= acc_miss;
            if (acc_hit) begin
                acc_bank_o <= ba_i;
                col_o      <= addr_i[COL_W-1:0];
                auto_pre_o <= addr_i[AP_BIT];
            end
            if (cke_i && cmd_now == CMD_LMR) begin
                mode_op_o <= {ba_i, addr_i};
            end
        end
    end

    always_comb begin
        burst_active_o = bu_active;
        pwr_mode_o     = 3'(pm_q);
    end

endmodule

// File: rtl/sdtrk_checker.sv
module sdtrk_checker #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int AP_BIT    = 10,
    parameter int BYTES     = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cke_i,
    input logic                 cs_n_i,
    input logic                 ras_n_i,
    input logic                 cas_n_i,
    input logic                 we_n_i,
    input logic [BA_W-1:0]      ba_i,
    input logic [ROW_W-1:0]     addr_i,
    input logic [BYTES-1:0]     dqm_i,
    input logic [2:0]           cmd_o,
    input logic [NUM_BANKS-1:0] bank_active_o,
    input logic                 acc_err_o,
    input logic                 burst_active_o,
    input logic [2:0]           pwr_mode_o,
    input logic [BYTES-1:0]     wr_be_o
);

    logic [2:0] strobes;
    logic       live;
    assign strobes = {ras_n_i, cas_n_i, we_n_i};
    assign live    = cke_i && !cs_n_i;

    AST_CS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_i && cs_n_i) |=> (cmd_o == 3'd0 && $stable(bank_active_o))); // R2

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (live && strobes == 3'b011) |=> bank_active_o[$past(ba_i)]); // R3

    AST_PRE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (live && strobes == 3'b010 && addr_i[AP_BIT]) |=> (bank_active_o == '0)); // R5

    AST_IDLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (live && (strobes == 3'b101 || strobes == 3'b100) && !bank_active_o[ba_i])
        |=> acc_err_o); // R7

    AST_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_i && pwr_mode_o == 3'd0 && burst_active_o) |=> (pwr_mode_o == 3'd4)); // R9

    AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_i && pwr_mode_o != 3'd0) |=> ($stable(pwr_mode_o) && $stable(bank_active_o))); // R10

    AST_WR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_be_o & dqm_i) == '0)); // R11

    AST_NO_BE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_i |-> (wr_be_o == '0)); // R11

endmodule

bind sdram_cmd_tracker sdtrk_checker #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .AP_BIT    (AP_BIT),
    .BYTES     (BYTES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cke_i          (cke_i),
    .cs_n_i         (cs_n_i),
    .ras_n_i        (ras_n_i),
    .cas_n_i        (cas_n_i),
    .we_n_i         (we_n_i),
    .ba_i           (ba_i),
    .addr_i         (addr_i),
    .dqm_i          (dqm_i),
    .cmd_o          (cmd_o),
    .bank_active_o  (bank_active_o),
    .acc_err_o      (acc_err_o),
    .burst_active_o (burst_active_o),
    .pwr_mode_o     (pwr_mode_o),
    .wr_be_o        (wr_be_o)
);

// File: tb/sdram_cmd_tracker_bench.sv
module sdram_cmd_tracker_bench;

    localparam int CLK_PERIOD = 10;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_LMR = 4'b0000;
    localparam logic [3:0] C_BST = 4'b0110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke_i = 1'b1;
    logic        cs_n_i = 1'b0, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
    logic [1:0]  ba_i = '0;
    logic [11:0] addr_i = '0;
    logic [3:0]  dqm_i = '0;
    logic [2:0]  cmd_o;
    logic [3:0]  bank_active_o;
    logic [47:0] open_rows_o;
    logic [1:0]  acc_bank_o;
    logic [8:0]  col_o;
    logic        auto_pre_o, acc_err_o, burst_active_o;
    logic [2:0]  pwr_mode_o;
    logic [13:0] mode_op_o;
    logic [3:0]  wr_be_o, rd_oe_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_tracker u_sdram_cmd_tracker (
        .clk(clk), .rst_n(rst_n), .cke_i(cke_i), .cs_n_i(cs_n_i),
        .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
        .ba_i(ba_i), .addr_i(addr_i), .dqm_i(dqm_i),
        .cmd_o(cmd_o), .bank_active_o(bank_active_o), .open_rows_o(open_rows_o),
        .acc_bank_o(acc_bank_o), .col_o(col_o), .auto_pre_o(auto_pre_o),
        .acc_err_o(acc_err_o), .burst_active_o(burst_active_o),
        .pwr_mode_o(pwr_mode_o), .mode_op_o(mode_op_o),
        .wr_be_o(wr_be_o), .rd_oe_o(rd_oe_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] c, input logic [1:0] ba, input logic [11:0] a,
                         input logic [3:0] dqm, input logic cke);
        @(negedge clk);
        {cs_n_i, ras_n_i, cas_n_i, we_n_i} = c;
        ba_i = ba; addr_i = a; dqm_i = dqm; cke_i = cke;
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic step(input logic [3:0] c, input logic [1:0] ba, input logic [11:0] a,
                        input logic [3:0] dqm, input logic cke);
        drive(c, ba, a, dqm, cke);
        tick();
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset cmd", 64'(cmd_o), 64'd0);
        check("R1 reset banks", 64'(bank_active_o), 64'd0);
        check("R1 reset pwr", 64'(pwr_mode_o), 64'd0);
        check("R1 reset opcode", 64'(mode_op_o), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_lmr;
        step(C_LMR, 2'b10, 12'h5A3, 4'h0, 1'b1);
        check("R13 opcode", 64'(mode_op_o), 64'h25A3);
        check("R1 cmd LMR", 64'(cmd_o), 64'd6);
    endtask

    task automatic t_activate;
        step(C_ACT, 2'd0, 12'hABC, 4'h0, 1'b1);
        check("R1 cmd ACT", 64'(cmd_o), 64'd1);
        check("R3 bank0 open", 64'(bank_active_o), 64'b0001);
        check("R3 row0", 64'(open_rows_o[11:0]), 64'hABC);
        step(C_ACT, 2'd2, 12'h123, 4'h0, 1'b1);
        check("R3 bank2 open", 64'(bank_active_o), 64'b0101);
        check("R3 row2", 64'(open_rows_o[35:24]), 64'h123);
    endtask

    task automatic t_cs_mask;
        step(4'b1011, 2'd1, 12'h777, 4'h0, 1'b1);
        check("R2 cmd masked", 64'(cmd_o), 64'd0);
        check("R2 banks unchanged", 64'(bank_active_o), 64'b0101);
    endtask

    task automatic t_idle_err;
        step(C_WR, 2'd3, 12'h1FF, 4'h0, 1'b1);
        check("R7 err pulse", 64'(acc_err_o), 64'd1);
        check("R7 no burst", 64'(burst_active_o), 64'd0);
        check("R7 col kept", 64'(col_o), 64'd0);
        step(C_NOP, 2'd0, 12'h000, 4'h0, 1'b1);
        check("R7 err one cycle", 64'(acc_err_o), 64'd0);
    endtask

    task automatic t_write_mask;
        drive(C_WR, 2'd0, 12'h045, 4'b0001, 1'b1);
        #1;
        check("R11 be cmd cycle", 64'(wr_be_o), 64'b1110);
        tick();
        check("R4 bank", 64'(acc_bank_o), 64'd0);
        check("R4 col", 64'(col_o), 64'h045);
        check("R4 ap", 64'(auto_pre_o), 64'd0);
        check("R1 cmd WR", 64'(cmd_o), 64'd3);
        for (int i = 1; i < 4; i++) begin
            check("R4 burst on", 64'(burst_active_o), 64'd1);
            drive(C_NOP, 2'd0, 12'h000, 4'b1000, 1'b1);
            #1;
            check("R11 be beat", 64'(wr_be_o), 64'b0111);
            tick();
        end
        check("R4 burst over", 64'(burst_active_o), 64'd0);
        drive(C_NOP, 2'd0, 12'h000, 4'b0000, 1'b1);
        #1;
        check("R11 no beat", 64'(wr_be_o), 64'b0000);
        tick();
    endtask

    task automatic t_read_mask;
        step(C_RD, 2'd0, 12'h010, 4'b0000, 1'b1);
        check("R12 latency k", 64'(rd_oe_o), 64'd0);
        step(C_NOP, 2'd0, 12'h000, 4'b0010, 1'b1);
        check("R12 latency k1", 64'(rd_oe_o), 64'd0);
        step(C_NOP, 2'd0, 12'h000, 4'b0000, 1'b1);
        check("R12 beat0", 64'(rd_oe_o), 64'b1111);
        step(C_NOP, 2'd0, 12'h000, 4'b0000, 1'b1);
        check("R12 beat1 masked", 64'(rd_oe_o), 64'b1101);
        step(C_NOP, 2'd0, 12'h000, 4'b0000, 1'b1);
        check("R12 beat2", 64'(rd_oe_o), 64'b1111);
        step(C_NOP, 2'd0, 12'h000, 4'b0000, 1'b1);
        check("R12 beat3", 64'(rd_oe_o), 64'b1111);
        step(C_NOP, 2'd0, 12'h000, 4'b0000, 1'b1);
        check("R12 after burst", 64'(rd_oe_o), 64'b0000);
    endtask

    task automatic t_bst;
        step(C_RD, 2'd2, 12'h003, 4'h0, 1'b1);
        check("R4 read burst", 64'(burst_active_o), 64'd1);
        step(C_BST, 2'd0, 12'h000, 4'h0, 1'b1);
        check("R8 burst stopped", 64'(burst_active_o), 64'd0);
        check("R1 cmd BST", 64'(cmd_o), 64'd7);
        check("R8 bank2 stays", 64'(bank_active_o), 64'b0101);
    endtask

    task automatic t_autopre;
        step(C_RD, 2'd2, 12'h407, 4'h0, 1'b1);
        check("R4 ap flag", 64'(auto_pre_o), 64'd1);
        check("R4 col ap", 64'(col_o), 64'h007);
        step(C_NOP, 2'd0, 12'h000, 4'h0, 1'b1);
        check("R6 still open 1", 64'(bank_active_o), 64'b0101);
        step(C_NOP, 2'd0, 12'h000, 4'h0, 1'b1);
        check("R6 still open 2", 64'(bank_active_o), 64'b0101);
        step(C_NOP, 2'd0, 12'h000, 4'h0, 1'b1);
        check("R6 closed at end", 64'(bank_active_o), 64'b0001);
        check("R6 burst ended", 64'(burst_active_o), 64'd0);
    endtask

    task automatic t_precharge;
        step(C_ACT, 2'd1, 12'h011, 4'h0, 1'b1);
        step(C_ACT, 2'd3, 12'h033, 4'h0, 1'b1);
        check("R3 three open", 64'(bank_active_o), 64'b1011);
        step(C_PRE, 2'd1, 12'h000, 4'h0, 1'b1);
        check("R5 single bank", 64'(bank_active_o), 64'b1001);
        step(C_PRE, 2'd0, 12'h400, 4'h0, 1'b1);
        check("R5 all banks", 64'(bank_active_o), 64'b0000);
    endtask

    task automatic t_power;
        step(C_NOP, 2'd0, 12'h000, 4'h0, 1'b0);
        check("R9 precharge pd", 64'(pwr_mode_o), 64'd1);
        check("R1 cmd nop low", 64'(cmd_o), 64'd0);
        step(C_NOP, 2'd0, 12'h000, 4'h0, 1'b0);
        check("R10 held low", 64'(pwr_mode_o), 64'd1);
        step(C_NOP, 2'd0, 12'h000, 4'h0, 1'b1);
        check("R10 wake", 64'(pwr_mode_o), 64'd0);
        step(C_REF, 2'd0, 12'h000, 4'h0, 1'b0);
        check("R9 self refresh", 64'(pwr_mode_o), 64'd2);
        step(C_NOP, 2'd0, 12'h000, 4'h0, 1'b1);
        check("R10 wake sr", 64'(pwr_mode_o), 64'd0);
        step(C_ACT, 2'd0, 12'h0AA, 4'h0, 1'b1);
        step(C_NOP, 2'd0, 12'h000, 4'h0, 1'b0);
        check("R9 active pd", 64'(pwr_mode_o), 64'd3);
        step(C_NOP, 2'd0, 12'h000, 4'h0, 1'b1);
        check("R10 wake apd", 64'(pwr_mode_o), 64'd0);
        step(C_RD, 2'd0, 12'h000, 4'h0, 1'b1);
        step(C_NOP, 2'd0, 12'h000, 4'h0, 1'b0);
        check("R9 suspend", 64'(pwr_mode_o), 64'd4);
        step(C_NOP, 2'd0, 12'h000, 4'h0, 1'b0);
        check("R10 burst frozen", 64'(burst_active_o), 64'd1);
        step(C_NOP, 2'd0, 12'h000, 4'h0, 1'b1);
        check("R10 wake suspend", 64'(pwr_mode_o), 64'd0);
        check("R10 burst resumes", 64'(burst_active_o), 64'd1);
        step(C_NOP, 2'd0, 12'h000, 4'h0, 1'b1);
        check("R10 burst one left", 64'(burst_active_o), 64'd1);
        step(C_NOP, 2'd0, 12'h000, 4'h0, 1'b1);
        check("R10 burst done", 64'(burst_active_o), 64'd0);
    endtask

    initial begin
        t_reset();
        t_lmr();
        t_activate();
        t_cs_mask();
        t_idle_err();
        t_write_mask();
        t_read_mask();
        t_bst();
        t_autopre();
        t_precharge();
        t_power();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule